// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block turns the 32 pins of a general-purpose I/O port into interrupt sources. Each pin has its own 4-bit sense code. The code picks the event that marks the pin pending: a rising edge, a falling edge, either edge, a high level or a low level. A per-pin detect-enable vector decides which pins may become pending at all. A separate unmask vector decides which pending pins reach the interrupt request lines. The unmask vector is changed through two write-1 strobe registers, one that sets unmask bits and one that clears them.

Software reads two pending vectors, raw and masked. It acknowledges edge events by writing ones to a clear register. There are two request lines. One serves pins 0 to 15 and the other serves pins 16 to 31. Pins arrive already synchronised to `clk`.

The register port is a plain single-cycle write strobe with a combinational read. There is no stream traffic, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `gpio_sense_irq`

## Requirements
- R1: After reset, all sense codes, detect enables and unmask bits read 0, the raw and masked pending vectors read 0, and both request lines are low.
- R2: The sense code of pin n sits in the register at byte offset 0x40 + 4*(n/8), in bits 4*(n%8)+3 down to 4*(n%8), and reads back as written.
- R3: Code 8 (rising edge) sets pin n's pending bit in the cycle after the pin is first sampled high following a low sample. The bit stays set after the pin returns low.
- R4: Code 9 (falling edge) sets the pending bit on a high-to-low transition only. A rising transition leaves the bit clear.
- R5: Code 12 (both edges) sets the pending bit on either transition.
- R6: Code 10 (high level) and code 11 (low level) make the pending bit follow the pin directly. Writing 1 to the clear register does not remove it while the level persists.
- R7: Any code outside 8..12 (for example 4 or 15) never produces a pending bit.
- R8: Offset 0x14 is a read/write detect-enable vector. A pin whose bit is 0 never becomes pending.
- R9: Writing ones to 0x18 sets unmask bits and writing ones to 0x1C clears them. Reading 0x1C or 0x18 returns the unmask vector, where 1 means the pin is unmasked.
- R10: Offset 0x20 reads the raw pending vector. Offset 0x24 reads the raw vector ANDed with the unmask vector.
- R11: Writing ones to 0x28 clears the matching edge-latched pending bits. If a new edge event and a clear hit the same pin in the same cycle, the bit stays set.
- R12: `irq_lo_o` is high exactly when a masked pending bit among pins 0..15 is set, and `irq_hi_o` is high exactly when one among pins 16..31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| pin_i | input | 32 | Synchronised pin levels |
| irq_lo_o | output | 1 | Request line for pins 0..15 |
| irq_hi_o | output | 1 | Request line for pins 16..31 |

## Verification
Single pins receive lone rising and falling transitions. These show the three edge codes apart from one another and confirm the latch holds after the pin returns. Held levels that are followed by a clear separate level codes from edge codes. Toggling pins that carry invalid codes or a cleared detect enable shows that neither can create an event. A clear issued in the same cycle as a fresh edge, together with pins on each side of the 16-pin split, tests clear priority and the routing to the two request lines.

// File: rtl/gsi_pkg.sv
package gsi_pkg;
  typedef enum logic [3:0] {
    SNS_RISE = 4'd8,
    SNS_FALL = 4'd9,
    SNS_HIGH = 4'd10,
    SNS_LOW  = 4'd11,
    SNS_BOTH = 4'd12
  } sense_e;

  localparam int CODE_W = 4;

  localparam logic [7:0] OFS_DETEN  = 8'h14;
  localparam logic [7:0] OFS_UNMASK = 8'h18;
  localparam logic [7:0] OFS_MASK   = 8'h1C;
  localparam logic [7:0] OFS_RAW    = 8'h20;
  localparam logic [7:0] OFS_MASKED = 8'h24;
  localparam logic [7:0] OFS_ACK    = 8'h28;
  localparam logic [7:0] OFS_SENSE0 = 8'h40;
endpackage

// File: rtl/gsi_regs.sv
module gsi_regs
  import gsi_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [NPINS-1:0]         wr_data_i,
  input  logic [AW-1:0]            rd_addr_i,
  output logic [NPINS-1:0]         rd_data_o,
  input  logic [NPINS-1:0]         raw_i,
  input  logic [NPINS-1:0]         masked_i,
  output logic [NPINS*CODE_W-1:0]  sense_o,
  output logic [NPINS-1:0]         deten_o,
  output logic [NPINS-1:0]         unmask_o,
  output logic [NPINS-1:0]         ack_o
);
  localparam int NSREG = (NPINS * CODE_W) / NPINS;

  logic [NPINS*CODE_W-1:0] sense_q;
  logic [NPINS-1:0]        deten_q;
  logic [NPINS-1:0]        unm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      deten_q <= '0;
      unm_q   <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        OFS_DETEN:  deten_q <= wr_data_i;
        OFS_UNMASK: unm_q   <= unm_q | wr_data_i;
        OFS_MASK:   unm_q   <= unm_q & ~wr_data_i;
        default: ;
      endcase
      for (int r = 0; r < NSREG; r++) begin
        if (wr_addr_i == AW'(int'(OFS_SENSE0) + 4 * r))
          sense_q[r*NPINS +: NPINS] <= wr_data_i;
      end
    end
  end

  assign ack_o    = (wr_en_i && wr_addr_i == OFS_ACK) ? wr_data_i : '0;
  assign sense_o  = sense_q;
  assign deten_o  = deten_q;
  assign unmask_o = unm_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      OFS_DETEN:            rd_data_o = deten_q;
      OFS_UNMASK, OFS_MASK: rd_data_o = unm_q;
      OFS_RAW:              rd_data_o = raw_i;
      OFS_MASKED:           rd_data_o = masked_i;
      default: ;
    endcase
    for (int r = 0; r < NSREG; r++) begin
      if (rd_addr_i == AW'(int'(OFS_SENSE0) + 4 * r))
        rd_data_o = sense_q[r*NPINS +: NPINS];
    end
  end

  // R9: a mask strobe leaves every written bit masked
  assert_mask_w1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == OFS_MASK) |=> ((unm_q & $past(wr_data_i)) == '0));

  // R9: an unmask strobe leaves every written bit unmasked
  assert_unmask_w1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == OFS_UNMASK) |=> ((~unm_q & $past(wr_data_i)) == '0));
endmodule

// File: rtl/gsi_detect.sv
module gsi_detect
  import gsi_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pin_i,
  input  logic [NPINS*CODE_W-1:0] sense_i,
  input  logic [NPINS-1:0]        deten_i,
  input  logic [NPINS-1:0]        ack_i,
  output logic [NPINS-1:0]        raw_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] set_v;
  logic [NPINS-1:0] edge_m;
  logic [NPINS-1:0] lvl_hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic              rise, fall;
    assign code = sense_i[i*CODE_W +: CODE_W];
    assign rise = pin_i[i] & ~prev_q[i];
    assign fall = ~pin_i[i] & prev_q[i];

    always_comb begin
      edge_m[i]  = 1'b0;
      set_v[i]   = 1'b0;
      lvl_hit[i] = 1'b0;
      case (code)
        SNS_RISE: begin edge_m[i] = 1'b1; set_v[i] = rise & deten_i[i]; end
        SNS_FALL: begin edge_m[i] = 1'b1; set_v[i] = fall & deten_i[i]; end
        SNS_BOTH: begin edge_m[i] = 1'b1; set_v[i] = (rise | fall) & deten_i[i]; end
        SNS_HIGH: lvl_hit[i] = pin_i[i] & deten_i[i];
        SNS_LOW:  lvl_hit[i] = ~pin_i[i] & deten_i[i];
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (!edge_m[i]) pend_q[i] <= 1'b0;
      else if (set_v[i])   pend_q[i] <= 1'b1;
      else if (ack_i[i])   pend_q[i] <= 1'b0;
    end

    // R11: a fresh event beats a simultaneous clear
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> pend_q[i]);

    // R11: a clear without a new event drops the latch
    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && !set_v[i]) |=> !pend_q[i]);

    // R8: a disabled pin cannot acquire a latched event
    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!deten_i[i] && !pend_q[i]) |=> !pend_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  assign raw_o = pend_q | lvl_hit;
endmodule

// File: rtl/gsi_irq_out.sv
module gsi_irq_out #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] unmask_i,
  output logic [NPINS-1:0] masked_o,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  localparam int HALF = NPINS / 2;

  assign masked_o = raw_i & unmask_i;
  assign irq_lo_o = |masked_o[HALF-1:0];
  assign irq_hi_o = |masked_o[NPINS-1:HALF];
endmodule

// File: rtl/gpio_sense_irq.sv
module gpio_sense_irq
  import gsi_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [NPINS-1:0] rd_data_o,
  input  logic [NPINS-1:0] pin_i,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  localparam int HALF = NPINS / 2;

  logic [NPINS*CODE_W-1:0] sense;
  logic [NPINS-1:0]        deten, unmask, ack, raw, masked;

  gsi_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .raw_i(raw), .masked_i(masked),
    .sense_o(sense), .deten_o(deten), .unmask_o(unmask), .ack_o(ack)
  );

  gsi_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .sense_i(sense), .deten_i(deten), .ack_i(ack), .raw_o(raw)
  );

  gsi_irq_out #(.NPINS(NPINS)) u_irq (
    .raw_i(raw), .unmask_i(unmask), .masked_o(masked),
    .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o)
  );

  // R12: each request line needs an unmasked raw source in its half
  assert_irq_lo_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo_o |-> ((raw[HALF-1:0] & unmask[HALF-1:0]) != '0));
  assert_irq_hi_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi_o |-> ((raw[NPINS-1:HALF] & unmask[NPINS-1:HALF]) != '0));
endmodule

// File: tb/gpio_sense_irq_tb.sv
module gpio_sense_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h20;
  logic [31:0] rd_data;
  logic [31:0] pins = '0;
  logic        irq_lo, irq_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  gpio_sense_irq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pin_i(pins), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  // behavioural reference state
  int          m_sns[32];
  logic [31:0] m_en, m_unm, m_pend, m_prev;

  function automatic bit is_edge(int c);
    return (c == 8) || (c == 9) || (c == 12);
  endfunction

  function automatic logic [31:0] m_raw();
    logic [31:0] v = m_pend;
    for (int i = 0; i < 32; i++) begin
      if (m_en[i] && ((m_sns[i] == 10 && pins[i]) || (m_sns[i] == 11 && !pins[i])))
        v[i] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [31:0] sense_word(int r);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w[4*k +: 4] = 4'(m_sns[8*r + k]);
    return w;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h14: return m_en;
      8'h18, 8'h1C: return m_unm;
      8'h20: return m_raw();
      8'h24: return m_raw() & m_unm;
      8'h40: return sense_word(0);
      8'h44: return sense_word(1);
      8'h48: return sense_word(2);
      8'h4C: return sense_word(3);
      default: return '0;
    endcase
  endfunction

  function automatic string addr_req(logic [7:0] a);
    case (a)
      8'h14: return "R8";
      8'h18, 8'h1C: return "R9";
      8'h20, 8'h24: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_sns[i] = 0;
    m_en = '0; m_unm = '0; m_pend = '0; m_prev = '0;
  endtask

  task automatic model_edge();
    for (int i = 0; i < 32; i++) begin
      bit r = pins[i] && !m_prev[i];
      bit f = !pins[i] && m_prev[i];
      bit ev = m_en[i] && ((m_sns[i] == 8 && r) || (m_sns[i] == 9 && f) ||
                           (m_sns[i] == 12 && (r || f)));
      if (!is_edge(m_sns[i])) m_pend[i] = 1'b0;
      else if (ev) m_pend[i] = 1'b1;
      else if (wr_en && wr_addr == 8'h28 && wr_data[i]) m_pend[i] = 1'b0;
    end
    m_prev = pins;
    if (wr_en) begin
      case (wr_addr)
        8'h14: m_en = wr_data;
        8'h18: m_unm = m_unm | wr_data;
        8'h1C: m_unm = m_unm & ~wr_data;
        8'h40, 8'h44, 8'h48, 8'h4C:
          for (int k = 0; k < 8; k++)
            m_sns[8*((wr_addr - 8'h40) / 4) + k] = int'(wr_data[4*k +: 4]);
        default: ;
      endcase
    end
  endtask

  // one clock: reference follows the edge, all outputs compared at negedge
  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    chk("R12", {31'd0, irq_lo}, {31'd0, |(m_raw() & m_unm & 32'h0000FFFF)});
    chk("R12", {31'd0, irq_hi}, {31'd0, |(m_raw() & m_unm & 32'hFFFF0000)});
    chk(addr_req(rd_addr), rd_data, m_read(rd_addr));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_code(int pin, int code);
    m_sns[pin] = code;
    wr(8'h40 + 8'(4 * (pin / 8)), sense_word(pin / 8));
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic set_pin(int p, bit v);
    pins[p] = v; step();
  endtask

  logic [31:0] v;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1: reset state
    rd(8'h20, v); chk("R1", v, 32'h0);
    rd(8'h24, v); chk("R1", v, 32'h0);
    rd(8'h1C, v); chk("R1", v, 32'h0);
    rd(8'h14, v); chk("R1", v, 32'h0);
    rd(8'h4C, v); chk("R1", v, 32'h0);
    chk("R1", {30'd0, irq_hi, irq_lo}, 32'h0);

    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);

    // R2: pin 10 high level -> reg 0x44 bits 11:8
    wr(8'h44, 32'h0000_0A00);
    rd(8'h44, v); chk("R2", v, 32'h0000_0A00);
    set_pin(10, 1);
    rd(8'h20, v); chk("R2", v[10], 1'b1);
    chk("R2", {31'd0, irq_lo}, 32'd1);
    set_pin(10, 0);
    rd(8'h20, v); chk("R2", v, 32'h0);

    // R3: rising edge on pin 3 (reg 0x40 bits 15:12)
    set_code(3, 8);
    set_pin(3, 1);
    rd(8'h20, v); chk("R3", v[3], 1'b1);
    set_pin(3, 0);
    rd(8'h20, v); chk("R3", v[3], 1'b1);
    wr(8'h28, 32'h8);
    rd(8'h20, v); chk("R11", v[3], 1'b0);

    // R4: falling edge on pin 20
    set_code(20, 9);
    set_pin(20, 1);
    rd(8'h20, v); chk("R4", v[20], 1'b0);
    set_pin(20, 0);
    rd(8'h20, v); chk("R4", v[20], 1'b1);
    chk("R12", {30'd0, irq_hi, irq_lo}, 32'h2);
    wr(8'h28, 32'h0010_0000);

    // R5: both edges on pin 31
    set_code(31, 12);
    set_pin(31, 1);
    rd(8'h20, v); chk("R5", v[31], 1'b1);
    wr(8'h28, 32'h8000_0000);
    set_pin(31, 0);
    rd(8'h20, v); chk("R5", v[31], 1'b1);
    wr(8'h28, 32'h8000_0000);
    rd(8'h20, v); chk("R5", v[31], 1'b0);

    // R6: low level on pin 0 survives a clear
    set_code(0, 11);
    rd(8'h20, v); chk("R6", v[0], 1'b1);
    wr(8'h28, 32'h1);
    rd(8'h20, v); chk("R6", v[0], 1'b1);
    set_pin(0, 1);
    rd(8'h20, v); chk("R6", v[0], 1'b0);

    // R7: codes 4 and 15 do nothing
    set_code(5, 4);
    set_code(6, 15);
    set_pin(5, 1); set_pin(6, 1); set_pin(5, 0); set_pin(6, 0);
    rd(8'h20, v); chk("R7", v & 32'h60, 32'h0);

    // R8: detect enable off for pin 3
    wr(8'h14, 32'hFFFF_FFF7);
    set_pin(3, 1); set_pin(3, 0);
    rd(8'h20, v); chk("R8", v[3], 1'b0);
    wr(8'h14, 32'hFFFF_FFFF);

    // R9 / R10: masking pin 3 after an event
    set_pin(3, 1);
    wr(8'h1C, 32'h8);
    rd(8'h1C, v); chk("R9", v, 32'hFFFF_FFF7);
    rd(8'h20, v); chk("R10", v[3], 1'b1);
    rd(8'h24, v); chk("R10", v[3], 1'b0);
    chk("R9", {31'd0, irq_lo}, 32'd0);
    wr(8'h18, 32'h8);
    chk("R9", {31'd0, irq_lo}, 32'd1);

    // R11: clear and new rising edge in the same cycle
    set_pin(3, 0);
    pins[3] = 1'b1;
    wr(8'h28, 32'h8);
    rd(8'h20, v); chk("R11", v[3], 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule